// File: doc/BRIEF.md
# Nibble-Serial Lightweight Block Cipher Encryption Core

This core encrypts one 64-bit block under an 80-bit key. It is built for the smallest area, so nearly all of its work passes through a 4-bit path. It contains a single 4-bit substitution box. The state update and the key schedule take turns on it. The key and the plaintext enter together, one nibble of each per accepted cycle, over twenty cycles. The ciphertext leaves one nibble per cycle, under a valid strobe.

Two storage words hold the cipher state (64 bits) and the key (80 bits). Each word works in two modes:

- **Nibble mode.** The word shifts left by four bits and takes a new nibble in at the low end. This mode is used for loading, for substitution and for readout.
- **Word mode.** The whole word changes in one cycle. The state receives the bit permutation. The key receives its rotate, substitute and counter update.

A round takes seventeen cycles: sixteen substitution steps followed by one word-mode step.

A sequencer drives the storage modes and the box select. It holds a load/nibble counter and a round counter.

Top module: `nibble_cipher_core`

## Requirements
- R1: While reset is held, and directly after it, `ready` is 1 and `ct_valid` is 0.
- R2: While `ready` is 1, each cycle with `ld_en` = 1 accepts one key nibble and one plaintext nibble. A cycle with `ld_en` = 0 accepts nothing and pauses the load. The twenty key nibbles form the key, most significant nibble first. The plaintext is the last sixteen of the twenty plaintext nibbles, most significant first.
- R3: The cycle after the 20th accepted nibble starts the rounds. There are ROUNDS rounds of 17 cycles each. `ct_valid` rises exactly 17*ROUNDS cycles after the 20th accepted nibble and stays high for exactly 16 cycles.
- R4: The 16 output nibbles, most significant first, equal the cipher's encryption of the loaded block, with these rules:
  - The substitution table for inputs 0..F is C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2.
  - State bit i moves to bit (16*i) mod 63 for i < 63, and bit 63 stays in place.
  - Each round first XORs key bits [79:16] into the state.
  - The key update rotates the key left by 61, substitutes bits [79:76], and XORs the round number (1..ROUNDS) into bits [19:15].
  - After the last round, key bits [79:16] are XORed into the state.
- R5: From the cycle after the 20th accepted nibble until the last output nibble, `ready` is 0. `ld_en`, `key_nib` and `pt_nib` have no effect on the result during this time.
- R6: `ready` returns to 1 in the cycle right after the last output nibble. A new load may begin in that same cycle.
- R7: With the default of 31 rounds and an unbroken load, one encryption takes 563 cycles, counted from the first accepted nibble through the last output nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_en | input | 1 | Load strobe; accepts one nibble pair when `ready` is 1 |
| key_nib | input | 4 | Key nibble, most significant first |
| pt_nib | input | 4 | Plaintext nibble, most significant first |
| ready | output | 1 | Core is idle or loading and accepts `ld_en` |
| ct_nib | output | 4 | Ciphertext nibble, valid while `ct_valid` is 1 |
| ct_valid | output | 1 | Ciphertext nibble strobe |

## Verification
The bench builds the core with its default of 31 rounds. This places the published known-answer vectors for the full-strength cipher within reach: all-zero and all-one keys and blocks are checked against fixed constants. At this setting the 563-cycle budget and the exact position of the output window can also be checked against the round count. The reference model computes each round on whole words, with a plain 61-bit rotation, and it advances on every clock. This exercises the nibble-wise key alignment, the 77-bit corrective rotation and the sharing of the box, under paused loads, back-to-back blocks and input noise while the core is busy.

// File: rtl/nibcore_pkg.sv
package nibcore_pkg;
  localparam int STATE_W    = 64;
  localparam int KEY_W      = 80;
  localparam int NIB_W      = 4;
  localparam int RC_W       = 5;
  localparam int KEY_NIBS   = KEY_W / NIB_W;
  localparam int STATE_NIBS = STATE_W / NIB_W;
  localparam int CNT_W      = $clog2(KEY_NIBS);

  // operation applied to a dual-mode storage word this cycle
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_LOAD,
    OP_SUBST,
    OP_ROT,
    OP_WORD
  } store_op_e;

  typedef enum logic [1:0] {
    PH_LOAD,
    PH_SUB,
    PH_PERM,
    PH_OUT
  } phase_e;

  function automatic logic [NIB_W-1:0] sbox4(input logic [NIB_W-1:0] x);
    case (x)
      4'h0: sbox4 = 4'hC;  4'h1: sbox4 = 4'h5;
      4'h2: sbox4 = 4'h6;  4'h3: sbox4 = 4'hB;
      4'h4: sbox4 = 4'h9;  4'h5: sbox4 = 4'h0;
      4'h6: sbox4 = 4'hA;  4'h7: sbox4 = 4'hD;
      4'h8: sbox4 = 4'h3;  4'h9: sbox4 = 4'hE;
      4'hA: sbox4 = 4'hF;  4'hB: sbox4 = 4'h8;
      4'hC: sbox4 = 4'h4;  4'hD: sbox4 = 4'h7;
      4'hE: sbox4 = 4'h1;  default: sbox4 = 4'h2;
    endcase
  endfunction

  // bit i moves to (16*i) mod 63; top bit fixed
  function automatic logic [STATE_W-1:0] perm64(input logic [STATE_W-1:0] s);
    logic [STATE_W-1:0] p;
    p = '0;
    for (int i = 0; i < STATE_W - 1; i++) p[(i * 16) % (STATE_W - 1)] = s[i];
    p[STATE_W-1] = s[STATE_W-1];
    return p;
  endfunction

  // the key has already turned by 64 during the round, so the
  // remaining turn to reach a 61-bit left rotation is 77 left
  function automatic logic [KEY_W-1:0] rotl77(input logic [KEY_W-1:0] k);
    return {k[2:0], k[KEY_W-1:3]};
  endfunction
endpackage

// File: rtl/nib_state_store.sv
module nib_state_store
  import nibcore_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  store_op_e          op,
  input  logic [NIB_W-1:0]   din,
  input  logic [NIB_W-1:0]   sb,
  output logic [STATE_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else begin
      case (op)
        OP_LOAD:  q <= {q[STATE_W-NIB_W-1:0], din};
        OP_SUBST: q <= {q[STATE_W-NIB_W-1:0], sb};
        OP_ROT:   q <= {q[STATE_W-NIB_W-1:0], q[STATE_W-1 -: NIB_W]};
        OP_WORD:  q <= perm64(q);
        default:  q <= q;
      endcase
    end
  end
endmodule

// File: rtl/nib_key_store.sv
module nib_key_store
  import nibcore_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  store_op_e        op,
  input  logic [NIB_W-1:0] din,
  input  logic [NIB_W-1:0] sb,
  input  logic [RC_W-1:0]  rc,
  output logic [NIB_W-1:0] upd_top,
  output logic [KEY_W-1:0] q
);
  logic [KEY_W-1:0] turned;
  logic [KEY_W-1:0] updated;

  always_comb begin
    turned  = rotl77(q);
    updated = turned;
    updated[KEY_W-1 -: NIB_W] = sb;
    updated[19:15] = turned[19:15] ^ rc;
  end

  assign upd_top = turned[KEY_W-1 -: NIB_W];

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else begin
      case (op)
        OP_LOAD: q <= {q[KEY_W-NIB_W-1:0], din};
        OP_ROT:  q <= {q[KEY_W-NIB_W-1:0], q[KEY_W-1 -: NIB_W]};
        OP_WORD: q <= updated;
        default: q <= q;
      endcase
    end
  end
endmodule

// File: rtl/nib_sequencer.sv
module nib_sequencer
  import nibcore_pkg::*;
#(
  parameter int ROUNDS = 31
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_en,
  output store_op_e       st_op,
  output store_op_e       key_op,
  output logic            sbox_sel,
  output logic [RC_W-1:0] rnd,
  output logic            load_phase,
  output logic            sub_step,
  output logic            perm_step,
  output logic            out_step
);
  phase_e           ph;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph  <= PH_LOAD;
      cnt <= '0;
      rnd <= '0;
    end else begin
      case (ph)
        PH_LOAD: if (ld_en) begin
          if (cnt == CNT_W'(KEY_NIBS - 1)) begin
            ph  <= PH_SUB;
            cnt <= '0;
            rnd <= RC_W'(1);
          end else cnt <= cnt + 1'b1;
        end
        PH_SUB: begin
          if (cnt == CNT_W'(STATE_NIBS - 1)) ph <= PH_PERM;
          cnt <= (cnt == CNT_W'(STATE_NIBS - 1)) ? '0 : cnt + 1'b1;
        end
        PH_PERM: begin
          cnt <= '0;
          if (rnd == RC_W'(ROUNDS)) ph <= PH_OUT;
          else begin
            rnd <= rnd + 1'b1;
            ph  <= PH_SUB;
          end
        end
        default: begin
          if (cnt == CNT_W'(STATE_NIBS - 1)) begin
            ph  <= PH_LOAD;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    st_op  = OP_HOLD;
    key_op = OP_HOLD;
    case (ph)
      PH_LOAD: if (ld_en) begin
        st_op  = OP_LOAD;
        key_op = OP_LOAD;
      end
      PH_SUB:  begin st_op = OP_SUBST; key_op = OP_ROT;  end
      PH_PERM: begin st_op = OP_WORD;  key_op = OP_WORD; end
      default: begin st_op = OP_ROT;   key_op = OP_ROT;  end
    endcase
  end

  assign load_phase = (ph == PH_LOAD);
  assign sub_step   = (ph == PH_SUB);
  assign perm_step  = (ph == PH_PERM);
  assign out_step   = (ph == PH_OUT);
  assign sbox_sel   = (ph == PH_PERM);
endmodule

// File: rtl/nibble_cipher_core.sv
module nibble_cipher_core
  import nibcore_pkg::*;
#(
  parameter int ROUNDS = 31
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_en,
  input  logic [3:0] key_nib,
  input  logic [3:0] pt_nib,
  output logic       ready,
  output logic [3:0] ct_nib,
  output logic       ct_valid
);
  store_op_e          st_op;
  store_op_e          key_op;
  logic               sbox_sel;
  logic [RC_W-1:0]    rnd;
  logic               load_phase;
  logic               sub_step;
  logic               perm_step;
  logic               out_step;
  logic [STATE_W-1:0] st_q;
  logic [KEY_W-1:0]   key_q;
  logic [NIB_W-1:0]   key_upd_top;
  logic [NIB_W-1:0]   mix_nib;
  logic [NIB_W-1:0]   sb_in;
  logic [NIB_W-1:0]   sb_out;

  nib_sequencer #(.ROUNDS(ROUNDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en),
    .st_op(st_op), .key_op(key_op), .sbox_sel(sbox_sel), .rnd(rnd),
    .load_phase(load_phase), .sub_step(sub_step),
    .perm_step(perm_step), .out_step(out_step)
  );

  // round-key nibble mixed into the leading state nibble
  assign mix_nib = st_q[STATE_W-1 -: NIB_W] ^ key_q[KEY_W-1 -: NIB_W];

  // the single shared substitution box
  assign sb_in  = sbox_sel ? key_upd_top : mix_nib;
  assign sb_out = sbox4(sb_in);

  nib_state_store u_state (
    .clk(clk), .rst_n(rst_n), .op(st_op), .din(pt_nib), .sb(sb_out), .q(st_q)
  );

  nib_key_store u_key (
    .clk(clk), .rst_n(rst_n), .op(key_op), .din(key_nib), .sb(sb_out),
    .rc(rnd), .upd_top(key_upd_top), .q(key_q)
  );

  assign ready    = load_phase;
  assign ct_valid = out_step;
  assign ct_nib   = mix_nib;
endmodule

// File: rtl/nibble_cipher_core_chk.sv
module nibble_cipher_core_chk (
  input logic clk,
  input logic rst_n,
  input logic ld_en,
  input logic ready,
  input logic ct_valid,
  input logic sub_step,
  input logic perm_step,
  input logic sbox_sel
);
  // R4: the key never claims the box while a state nibble uses it
  p_sbox_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sbox_sel |-> !sub_step);

  // R3: substitution run is closed by a word-mode step
  p_perm_after_sub_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sub_step) |-> perm_step);

  // R3: word-mode step lasts a single cycle
  p_perm_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    perm_step |=> !perm_step);

  // R3: output window opens right after the last word-mode step
  p_out_after_perm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ct_valid) |-> $past(perm_step));

  // R5: no acceptance while rounds or readout are running
  p_busy_not_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_step || perm_step || ct_valid) |-> !ready);

  // R6: ready comes back the cycle the window closes
  p_ready_after_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ct_valid) |-> ready);

  // R2: the first round starts only from an accepted load nibble
  p_start_from_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sub_step) && !$past(perm_step)) |-> $past(ld_en));
endmodule

bind nibble_cipher_core nibble_cipher_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ready(ready),
  .ct_valid(ct_valid), .sub_step(sub_step), .perm_step(perm_step),
  .sbox_sel(sbox_sel)
);

// File: tb/nibble_cipher_core_test.sv
`timescale 1ns/1ps
module nibble_cipher_core_test;
  localparam int ROUNDS = 31;
  localparam int WIN    = 17 * ROUNDS;
  localparam int FINISH = WIN + 16;
  localparam logic [63:0] SB_TAB = 64'h21748FE3DA09B65C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld_en = 1'b0;
  logic [3:0] key_nib = '0;
  logic [3:0] pt_nib = '0;
  logic       ready;
  logic [3:0] ct_nib;
  logic       ct_valid;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  nibble_cipher_core #(.ROUNDS(ROUNDS)) uut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .key_nib(key_nib),
    .pt_nib(pt_nib), .ready(ready), .ct_nib(ct_nib), .ct_valid(ct_valid)
  );

  function automatic logic [3:0] sb(input logic [3:0] x);
    return SB_TAB[x*4 +: 4];
  endfunction

  function automatic logic [63:0] ref_enc(input logic [63:0] pt, input logic [79:0] key);
    logic [63:0] s, t;
    logic [79:0] k;
    s = pt;
    k = key;
    for (int r = 1; r <= ROUNDS; r++) begin
      s = s ^ k[79:16];
      for (int n = 0; n < 16; n++) t[n*4 +: 4] = sb(s[n*4 +: 4]);
      for (int b = 0; b < 64; b++) s[(b % 4) * 16 + b / 4] = t[b];
      k = {k[18:0], k[79:19]};
      k[79:76] = sb(k[79:76]);
      k[19:15] = k[19:15] ^ 5'(r);
    end
    return s ^ k[79:16];
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference, advanced every clock
  bit          m_busy = 0;
  int          m_ld = 0;
  int          m_cnt = 0;
  int          m_gap = 0;
  int          cyc = 0;
  int          t0 = 0;
  logic [79:0] m_key = '0;
  logic [63:0] m_pt = '0;
  logic [63:0] m_exp = '0;
  logic [63:0] last_exp = '0;
  bit          monitor_on = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_ld = 0; m_cnt = 0; m_gap = 0;
    end else if (!m_busy) begin
      if (ld_en) begin
        if (m_ld == 0) begin t0 = cyc; m_gap = 0; end
        m_key = {m_key[75:0], key_nib};
        m_pt  = {m_pt[59:0], pt_nib};
        m_ld++;
        if (m_ld == 20) begin
          m_busy = 1;
          m_cnt  = 0;
          m_exp  = ref_enc(m_pt, m_key);
        end
      end else if (m_ld > 0) m_gap++;
    end else begin
      m_cnt++;
      if (m_cnt == FINISH) begin
        m_busy = 0;
        m_ld = 0;
        // R7: total span with paused cycles removed
        check((cyc - t0 + 1 - m_gap) == 20 + FINISH, "R7 cycles",
              64'(cyc - t0 + 1 - m_gap), 64'(20 + FINISH));
      end
    end
  end

  // per-cycle comparison, away from the active edge
  logic [63:0] cap = '0;
  int          ncap = 0;
  bit          prev_valid = 0;
  always @(negedge clk) begin
    if (monitor_on) begin
      bit ev;
      ev = m_busy && (m_cnt >= WIN) && (m_cnt < FINISH);
      check(ready == !m_busy, "R5 ready", 64'(ready), 64'(!m_busy));
      check(ct_valid == ev, "R3 ct_valid", 64'(ct_valid), 64'(ev));
      if (ev && ct_valid) begin
        check(ct_nib == m_exp[63 - 4 * (m_cnt - WIN) -: 4], "R4 nibble",
              64'(ct_nib), 64'(m_exp[63 - 4 * (m_cnt - WIN) -: 4]));
      end
      if (ct_valid) begin
        cap = {cap[59:0], ct_nib};
        ncap++;
        if (ncap == 16) begin
          last_exp = m_exp;
          check(cap == m_exp, "R4 block", cap, m_exp);
        end
      end else if (prev_valid) begin
        check(ncap == 16, "R3 window length", 64'(ncap), 64'd16);
        check(ready == 1'b1, "R6 ready after output", 64'(ready), 64'd1);
        ncap = 0;
      end
      prev_valid = ct_valid;
    end
  end

  // caller is at a negedge; leaves at a negedge with ld_en low
  task automatic do_load(input logic [79:0] key, input logic [63:0] pt, input int gap_every);
    for (int n = 0; n < 20; n++) begin
      if (n > 0) @(negedge clk);
      if (gap_every != 0 && n % gap_every == gap_every - 1) begin
        ld_en   = 1'b0;
        key_nib = 4'($urandom);
        pt_nib  = 4'($urandom);
        @(negedge clk);
      end
      ld_en   = 1'b1;
      key_nib = key[79 - 4 * n -: 4];
      pt_nib  = (n < 4) ? 4'($urandom) : pt[63 - 4 * (n - 4) -: 4];
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic wait_ready(input bit noisy);
    while (!ready) begin
      if (noisy) begin
        ld_en   = 1'($urandom);
        key_nib = 4'($urandom);
        pt_nib  = 4'($urandom);
      end
      @(negedge clk);
    end
    ld_en = 1'b0;
  endtask

  task automatic run_kat(input logic [79:0] key, input logic [63:0] pt,
                         input logic [63:0] ct, input bit noisy);
    do_load(key, pt, 0);
    wait_ready(noisy);
    check(last_exp == ct, "R4 known answer", last_exp, ct);
  endtask

  initial begin
    // R4: reference model against published answers
    check(ref_enc(64'h0, 80'h0) == 64'h5579C1387B228445, "R4 model kat0",
          ref_enc(64'h0, 80'h0), 64'h5579C1387B228445);
    check(ref_enc(64'h0, {80{1'b1}}) == 64'hE72C46C0F5945049, "R4 model kat1",
          ref_enc(64'h0, {80{1'b1}}), 64'hE72C46C0F5945049);

    repeat (3) @(negedge clk);
    check(ready == 1'b1, "R1 ready in reset", 64'(ready), 64'd1);
    check(ct_valid == 1'b0, "R1 valid in reset", 64'(ct_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    monitor_on = 1;
    check(ready == 1'b1 && ct_valid == 1'b0, "R1 after reset",
          {ready, ct_valid}, 64'b10);

    run_kat(80'h0, 64'h0, 64'h5579C1387B228445, 0);
    run_kat({80{1'b1}}, 64'h0, 64'hE72C46C0F5945049, 0);
    // R5: noise on the inputs while busy
    run_kat(80'h0, {64{1'b1}}, 64'hA112FFC72F68417B, 1);
    // R6: next load starts in the first ready cycle
    run_kat({80{1'b1}}, {64{1'b1}}, 64'h3333DCD3213210D2, 1);

    // R2: paused loads
    do_load(80'h0123456789ABCDEF0123, 64'hFEDCBA9876543210, 3);
    wait_ready(0);
    do_load(80'hA5A5_0F0F_3C3C_9696_C3C3, 64'h1357_9BDF_0246_8ACE, 7);
    wait_ready(1);
    for (int i = 0; i < 2; i++) begin
      do_load({$urandom, $urandom, 16'($urandom)}, {$urandom, $urandom}, 0);
      wait_ready(1);
    end
    repeat (4) @(negedge clk);
    check(ready == 1'b1 && ct_valid == 1'b0, "R6 idle at end",
          {ready, ct_valid}, 64'b10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule